// File: doc/BRIEF.md
# USB 2.0 PHY Power Sequencer

This block brings a USB 2.0 PHY out of standby and puts it back, on behalf of any number of software users. Each user sends a one-cycle start request when it needs the PHY and a one-cycle stop request when it is finished. A use counter tracks the users. Only the start request that finds the counter at zero runs the power-up program. Only the stop request that takes the counter from one to zero powers the PHY down. Every other request changes the count and nothing else.

The power-up program is a fixed series of register writes on a simple write port. It clears standby, starts the PLL, and, when a tuning bank is fitted, writes two signal-quality tuning values. It then polls the PHY status word at a fixed interval until the PHY reports ready, or until a retry limit is reached. After a ready status it releases the PHY reset, writes a port-configuration word built from board strap inputs, and writes zero to two bus-alignment registers. If the poll runs out, the block raises an error and stops before the reset release. A request that arrives while a program is running is remembered and handled once the block is idle again.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: A start request that finds the use count at zero begins the power-up program. A start request that finds a nonzero count makes no register write and only pulses `done`. Every accepted start request increments the count, and the count saturates at its maximum.
- R2: The program begins with two writes to the control target (`reg_sel`=0): first 0x1 (PHY enable, bit 0), then 0x3 (PHY enable plus PLL enable, bit 1).
- R3: With `tune_present`=1, the next two writes go to targets 1 and 2. They carry 0x41 and 0x0D when `ferrite_opt`=1, and 0x00 and 0x07 otherwise. With `tune_present`=0, no tuning write is made.
- R4: In the poll phase, `stat_rd` pulses once every POLL_US microseconds of the CLK_HZ clock, starting one interval after the poll phase is entered. `stat_word` is sampled on that pulse, and only the exact value 0xC000_0000 counts as ready.
- R5: If POLL_MAX polls pass without a ready status, `error` is set, `done` pulses, and no further write is made. The count still keeps the increment. `error` stays set until the next power-up program begins.
- R6: After a ready status, the block writes 0x7 to the control target. It then writes the port word to target 3, writes zero to target 4 and then to target 5, and pulses `done`.
- R7: In the port word, bit 0 = `port1_func`, bit 4 = `pen_level`, bit 8+i = `ovc_sel[i]`, and the over-current polarity `ovc_act_hi[0]`, `[1]` and `[2]` sits at bits 3, 1 and 6. All other bits are zero.
- R8: A stop request with a nonzero count decrements it. Only the step from 1 to 0 writes 0x0 to the control target before `done`. Other stop requests only pulse `done`.
- R9: A stop request with the count at zero makes no write, gives no `done`, and sets the sticky `underflow` flag. Only reset clears the flag.
- R10: `busy` is high while a program runs, and register writes and status reads happen only then. Requests that arrive while `busy` is high are held. When the block is idle again, a held start is served before a held stop.
- R11: After reset, `busy`, `done`, `error`, `underflow`, `reg_wr` and `stat_rd` are low and the use count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | One-cycle start request from a user |
| shut_req | input | 1 | One-cycle stop request from a user |
| tune_present | input | 1 | Tuning register bank is fitted |
| ferrite_opt | input | 1 | Board has a ferrite bead; selects the tuning values |
| port1_func | input | 1 | Port 1 runs in device (function) mode |
| pen_level | input | 1 | Output level of the power-enable pin |
| ovc_sel | input | 3 | Over-current pin select per port |
| ovc_act_hi | input | 3 | Over-current polarity per port, 1 = active high |
| reg_wr | output | 1 | PHY register write strobe |
| reg_sel | output | 3 | Write target: 0 control, 1 tune A, 2 tune B, 3 port, 4 align E, 5 align O |
| reg_wdata | output | 32 | Write data |
| stat_rd | output | 1 | Status sample strobe |
| stat_word | input | 32 | PHY status word |
| busy | output | 1 | Program running; new requests are held |
| done | output | 1 | One-cycle pulse when a request has been served |
| error | output | 1 | Last power-up timed out in the poll phase |
| underflow | output | 1 | Sticky: a stop request arrived with no users |

## Verification
The bench builds the block with CLK_HZ = 1 MHz, POLL_US = 10 and POLL_MAX = 6. One poll interval is then ten clock cycles, and a timeout takes sixty, so the bench can check both the exact poll spacing and the full retry count. CNT_W = 3 keeps the counter small. A PHY model in the bench reports ready 25 cycles after PLL enable, or can be set to answer with a stray extra status bit or never to answer, which covers both the exact-match rule and the timeout path.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STBY,
        ST_PLL,
        ST_TUNE_A,
        ST_TUNE_B,
        ST_POLL,
        ST_RST,
        ST_PORT,
        ST_ALN_E,
        ST_ALN_O,
        ST_DOWN
    } seq_state_e;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_TUNE_A = 3'd1,
        SEL_TUNE_B = 3'd2,
        SEL_PORT   = 3'd3,
        SEL_ALN_E  = 3'd4,
        SEL_ALN_O  = 3'd5
    } reg_sel_e;

    localparam logic [31:0] CTRL_PHY_ON  = 32'h0000_0001;
    localparam logic [31:0] CTRL_PLL_ON  = 32'h0000_0003;
    localparam logic [31:0] CTRL_RUN     = 32'h0000_0007;
    localparam logic [31:0] READY_WORD   = 32'hC000_0000;

    localparam logic [31:0] TUNE_A_BEAD  = 32'h0000_0041;
    localparam logic [31:0] TUNE_B_BEAD  = 32'h0000_000D;
    localparam logic [31:0] TUNE_A_PLAIN = 32'h0000_0000;
    localparam logic [31:0] TUNE_B_PLAIN = 32'h0000_0007;

endpackage

// File: rtl/poll_pacer.sv
module poll_pacer #(
    parameter int TICK_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = (TICK_CYC < 2) ? 1 : $clog2(TICK_CYC);
    localparam logic [TW-1:0] LAST = TW'(TICK_CYC - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/port_word_fmt.sv
module port_word_fmt (
    input  logic        port1_func,
    input  logic        pen_level,
    input  logic [2:0]  ovc_sel,
    input  logic [2:0]  ovc_act_hi,
    output logic [31:0] word
);
    localparam int NPORT = 3;
    localparam int SEL_BASE = 8;
    localparam int POL_POS [NPORT] = '{3, 1, 6};

    always_comb begin
        word    = '0;
        word[0] = port1_func;
        word[4] = pen_level;
        for (int i = 0; i < NPORT; i++) begin
            word[SEL_BASE + i] = ovc_sel[i];
            word[POL_POS[i]]   = ovc_act_hi[i];
        end
    end
endmodule

// File: rtl/usbphy_pwr_seq.sv
module usbphy_pwr_seq
    import usbphy_seq_pkg::*;
#(
    parameter int CLK_HZ   = 48_000_000,
    parameter int POLL_US  = 10,
    parameter int POLL_MAX = 1024,
    parameter int CNT_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_req,
    input  logic        shut_req,
    input  logic        tune_present,
    input  logic        ferrite_opt,
    input  logic        port1_func,
    input  logic        pen_level,
    input  logic [2:0]  ovc_sel,
    input  logic [2:0]  ovc_act_hi,
    output logic        reg_wr,
    output logic [2:0]  reg_sel,
    output logic [31:0] reg_wdata,
    output logic        stat_rd,
    input  logic [31:0] stat_word,
    output logic        busy,
    output logic        done,
    output logic        error,
    output logic        underflow
);
    localparam int RAW_TICK = (CLK_HZ / 1_000_000) * POLL_US;
    localparam int TICK_CYC = (RAW_TICK < 1) ? 1 : RAW_TICK;
    localparam int RETRY_W  = $clog2(POLL_MAX + 1);
    localparam logic [RETRY_W-1:0] RETRY_LAST = RETRY_W'(POLL_MAX - 1);
    localparam logic [CNT_W-1:0]   CNT_MAX    = '1;
    localparam logic [CNT_W-1:0]   CNT_ONE    = CNT_W'(1);

    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [RETRY_W-1:0] retry;
        logic               pend_init;
        logic               pend_shut;
        logic               err;
        logic               unf;
        logic               done;
    } seq_regs_t;

    seq_regs_t d, q;

    logic        tick;
    logic [31:0] port_word;
    logic [CNT_W-1:0] use_cnt;
    logic        want_init, want_shut;

    poll_pacer #(.TICK_CYC(TICK_CYC)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st == ST_POLL),
        .tick  (tick)
    );

    port_word_fmt u_fmt (
        .port1_func (port1_func),
        .pen_level  (pen_level),
        .ovc_sel    (ovc_sel),
        .ovc_act_hi (ovc_act_hi),
        .word       (port_word)
    );

    assign want_init = init_req | q.pend_init;
    assign want_shut = shut_req | q.pend_shut;
    assign use_cnt   = q.cnt;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        reg_wr    = 1'b0;
        reg_sel   = SEL_CTRL;
        reg_wdata = '0;
        stat_rd   = 1'b0;

        if (q.st != ST_IDLE) begin
            d.pend_init = want_init;
            d.pend_shut = want_shut;
        end

        case (q.st)
            ST_IDLE: begin
                if (want_init) begin
                    d.pend_init = 1'b0;
                    d.pend_shut = want_shut;
                    if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
                    if (q.cnt == '0) begin
                        d.st    = ST_STBY;
                        d.err   = 1'b0;
                        d.retry = '0;
                    end else begin
                        d.done = 1'b1;
                    end
                end else if (want_shut) begin
                    d.pend_shut = 1'b0;
                    if (q.cnt == '0) begin
                        d.unf = 1'b1;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                        if (q.cnt == CNT_ONE) d.st   = ST_DOWN;
                        else                  d.done = 1'b1;
                    end
                end
            end
            ST_STBY: begin
                reg_wr    = 1'b1;
                reg_wdata = CTRL_PHY_ON;
                d.st      = ST_PLL;
            end
            ST_PLL: begin
                reg_wr    = 1'b1;
                reg_wdata = CTRL_PLL_ON;
                d.st      = tune_present ? ST_TUNE_A : ST_POLL;
            end
            ST_TUNE_A: begin
                reg_wr    = 1'b1;
                reg_sel   = SEL_TUNE_A;
                reg_wdata = ferrite_opt ? TUNE_A_BEAD : TUNE_A_PLAIN;
                d.st      = ST_TUNE_B;
            end
            ST_TUNE_B: begin
                reg_wr    = 1'b1;
                reg_sel   = SEL_TUNE_B;
                reg_wdata = ferrite_opt ? TUNE_B_BEAD : TUNE_B_PLAIN;
                d.st      = ST_POLL;
            end
            ST_POLL: begin
                if (tick) begin
                    stat_rd = 1'b1;
                    if (stat_word == READY_WORD) begin
                        d.st = ST_RST;
                    end else if (q.retry == RETRY_LAST) begin
                        d.st   = ST_IDLE;
                        d.err  = 1'b1;
                        d.done = 1'b1;
                    end else begin
                        d.retry = q.retry + 1'b1;
                    end
                end
            end
            ST_RST: begin
                reg_wr    = 1'b1;
                reg_wdata = CTRL_RUN;
                d.st      = ST_PORT;
            end
            ST_PORT: begin
                reg_wr    = 1'b1;
                reg_sel   = SEL_PORT;
                reg_wdata = port_word;
                d.st      = ST_ALN_E;
            end
            ST_ALN_E: begin
                reg_wr  = 1'b1;
                reg_sel = SEL_ALN_E;
                d.st    = ST_ALN_O;
            end
            ST_ALN_O: begin
                reg_wr  = 1'b1;
                reg_sel = SEL_ALN_O;
                d.st    = ST_IDLE;
                d.done  = 1'b1;
            end
            ST_DOWN: begin
                reg_wr = 1'b1;
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.cnt       <= '0;
            q.retry     <= '0;
            q.pend_init <= 1'b0;
            q.pend_shut <= 1'b0;
            q.err       <= 1'b0;
            q.unf       <= 1'b0;
            q.done      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign error     = q.err;
    assign underflow = q.unf;
endmodule

// File: rtl/usbphy_pwr_seq_chk.sv
module usbphy_pwr_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic             underflow,
    input logic             reg_wr,
    input logic [2:0]       reg_sel,
    input logic [31:0]      reg_wdata,
    input logic             stat_rd,
    input logic [31:0]      stat_word,
    input logic [CNT_W-1:0] use_cnt
);
    AST_WR_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || stat_rd) |-> busy);  // R10

    AST_READY_TO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && stat_word == 32'hC000_0000) |=>
        (reg_wr && reg_sel == 3'd0 && reg_wdata == 32'h7));  // R6

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);  // R9

    AST_ERR_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> $past(stat_rd));  // R5

    AST_OFF_LAST_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 3'd0 && reg_wdata == 32'h0) |-> (use_cnt == '0));  // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R1
endmodule

bind usbphy_pwr_seq usbphy_pwr_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .underflow (underflow),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .stat_rd   (stat_rd),
    .stat_word (stat_word),
    .use_cnt   (use_cnt)
);

// File: tb/sim_usbphy_pwr_seq.sv
`timescale 1ns/1ps
module sim_usbphy_pwr_seq;
    localparam int POLL_MAX = 6;
    localparam int TICK     = 10;
    localparam int PHY_LAT  = 25;

    logic clk = 1'b0, rst_n = 1'b0;
    logic init_req = 0, shut_req = 0, tune_present = 0, ferrite_opt = 0;
    logic port1_func = 0, pen_level = 0;
    logic [2:0] ovc_sel = '0, ovc_act_hi = '0;
    logic reg_wr, stat_rd, busy, done, error, underflow;
    logic [2:0] reg_sel;
    logic [31:0] reg_wdata, stat_word;

    always #2 clk = ~clk;

    usbphy_pwr_seq #(.CLK_HZ(1_000_000), .POLL_US(10), .POLL_MAX(POLL_MAX), .CNT_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .shut_req(shut_req),
        .tune_present(tune_present), .ferrite_opt(ferrite_opt),
        .port1_func(port1_func), .pen_level(pen_level), .ovc_sel(ovc_sel),
        .ovc_act_hi(ovc_act_hi), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .stat_rd(stat_rd), .stat_word(stat_word),
        .busy(busy), .done(done), .error(error), .underflow(underflow));

    int total = 0, bad = 0;
    int cyc = 0;
    int log_n = 0, done_n = 0, rd_n = 0;
    logic [2:0]  log_sel [64];
    logic [31:0] log_dat [64];
    int rd_time [16];

    // PHY model: 0 normal, 1 silent, 2 ready word carries a stray bit
    int  phy_mode = 0;
    bit  phy_arm = 0;
    int  phy_cnt = 0;
    assign stat_word = (phy_mode == 1) ? 32'h0 :
                       (phy_arm && phy_cnt >= PHY_LAT) ?
                       (32'hC000_0000 | ((phy_mode == 2) ? 32'h1 : 32'h0)) : 32'h4000_0000;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (log_n < 64) begin log_sel[log_n] = reg_sel; log_dat[log_n] = reg_wdata; end
                log_n++;
                if (reg_sel == 3'd0 && reg_wdata[1]) begin phy_arm = 1; phy_cnt = 0; end
                if (reg_sel == 3'd0 && reg_wdata == 32'h0) phy_arm = 0;
            end else if (phy_arm && phy_cnt < PHY_LAT) phy_cnt++;
            if (stat_rd) begin
                if (rd_n < 16) rd_time[rd_n] = cyc;
                rd_n++;
            end
            if (done) done_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_wr(input int idx, input logic [2:0] s, input logic [31:0] v, input string req);
        chk(idx < log_n && log_sel[idx] == s, req, $sformatf("write %0d target", idx), log_sel[idx], s);
        chk(idx < log_n && log_dat[idx] == v, req, $sformatf("write %0d data", idx), log_dat[idx], v);
    endtask

    function automatic logic [31:0] exp_port(input logic f, input logic p,
                                             input logic [2:0] s, input logic [2:0] a);
        logic [31:0] w = '0;
        w[0] = f; w[4] = p;
        w[8] = s[0]; w[9] = s[1]; w[10] = s[2];
        w[3] = a[0]; w[1] = a[1]; w[6] = a[2];
        return w;
    endfunction

    task automatic clear_logs();
        @(negedge clk);
        log_n = 0; rd_n = 0;
    endtask

    task automatic pulse_init();
        @(negedge clk) init_req = 1;
        @(negedge clk) init_req = 0;
    endtask

    task automatic pulse_shut();
        @(negedge clk) shut_req = 1;
        @(negedge clk) shut_req = 0;
    endtask

    task automatic wait_done(input int n, input string req);
        int start = done_n;
        int k = 0;
        while (done_n < start + n && k < 3000) begin @(negedge clk); k++; end
        chk(done_n >= start + n, req, "done pulses", done_n - start, n);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !error && !underflow, "R11", "status after reset",
            {busy, done, error, underflow}, 0);
        chk(!reg_wr && !stat_rd && log_n == 0, "R11", "no activity after reset", log_n, 0);
    endtask

    task automatic t_up_tuned();
        logic [31:0] pw;
        tune_present = 1; ferrite_opt = 1;
        port1_func = 1; pen_level = 0; ovc_sel = 3'b101; ovc_act_hi = 3'b010;
        pw = exp_port(1, 0, 3'b101, 3'b010);
        clear_logs();
        pulse_init();
        chk(busy == 1, "R10", "busy during power-up", busy, 1);
        wait_done(1, "R1");
        chk(log_n == 8, "R6", "write count tuned", log_n, 8);
        chk_wr(0, 3'd0, 32'h1, "R2");
        chk_wr(1, 3'd0, 32'h3, "R2");
        chk_wr(2, 3'd1, 32'h41, "R3");
        chk_wr(3, 3'd2, 32'h0D, "R3");
        chk_wr(4, 3'd0, 32'h7, "R6");
        chk_wr(5, 3'd3, pw, "R7");
        chk_wr(6, 3'd4, 32'h0, "R6");
        chk_wr(7, 3'd5, 32'h0, "R6");
        chk(rd_n >= 2, "R4", "poll count", rd_n, 3);
        chk(rd_n >= 2 && rd_time[1] - rd_time[0] == TICK, "R4", "poll spacing",
            rd_time[1] - rd_time[0], TICK);
        chk(error == 0 && busy == 0, "R6", "clean finish", {error, busy}, 0);
    endtask

    task automatic t_second_init();
        clear_logs();
        pulse_init();
        wait_done(1, "R1");
        chk(log_n == 0, "R1", "second user writes nothing", log_n, 0);
    endtask

    task automatic t_shut_pair();
        clear_logs();
        pulse_shut();
        wait_done(1, "R8");
        chk(log_n == 0, "R8", "non-last stop writes nothing", log_n, 0);
        pulse_shut();
        wait_done(1, "R8");
        chk(log_n == 1, "R8", "last stop write count", log_n, 1);
        chk_wr(0, 3'd0, 32'h0, "R8");
    endtask

    task automatic t_underflow();
        int d0;
        clear_logs();
        d0 = done_n;
        pulse_shut();
        repeat (20) @(negedge clk);
        chk(underflow == 1, "R9", "underflow flag", underflow, 1);
        chk(log_n == 0 && done_n == d0, "R9", "ignored stop activity", log_n + done_n - d0, 0);
    endtask

    task automatic t_up_plain(input bit tune);
        logic [31:0] pw;
        tune_present = tune; ferrite_opt = 0;
        port1_func = 0; pen_level = 1; ovc_sel = 3'b010; ovc_act_hi = 3'b101;
        pw = exp_port(0, 1, 3'b010, 3'b101);
        clear_logs();
        pulse_init();
        wait_done(1, "R3");
        if (tune) begin
            chk(log_n == 8, "R3", "write count plain", log_n, 8);
            chk_wr(2, 3'd1, 32'h00, "R3");
            chk_wr(3, 3'd2, 32'h07, "R3");
            chk_wr(5, 3'd3, pw, "R7");
        end else begin
            chk(log_n == 6, "R3", "write count untuned", log_n, 6);
            chk_wr(1, 3'd0, 32'h3, "R2");
            chk_wr(2, 3'd0, 32'h7, "R3");
            chk_wr(3, 3'd3, pw, "R7");
        end
        pulse_shut();
        wait_done(1, "R8");
    endtask

    task automatic t_timeout(input int mode);
        phy_mode = mode;
        tune_present = 1; ferrite_opt = 1;
        clear_logs();
        pulse_init();
        wait_done(1, "R5");
        chk(error == 1, "R5", "error after timeout", error, 1);
        chk(rd_n == POLL_MAX, "R5", "poll count at timeout", rd_n, POLL_MAX);
        chk(log_n == 4, "R5", "no reset release after timeout", log_n, 4);
        phy_mode = 0;
        clear_logs();
        pulse_init();
        wait_done(1, "R5");
        chk(log_n == 0, "R5", "count kept after timeout", log_n, 0);
        pulse_shut();
        wait_done(1, "R5");
        chk(log_n == 0, "R5", "two users remained", log_n, 0);
        pulse_shut();
        wait_done(1, "R5");
        chk(log_n == 1 && log_dat[0] == 0, "R5", "power-down after timeout", log_n, 1);
    endtask

    task automatic t_defer();
        clear_logs();
        pulse_init();
        pulse_shut();
        pulse_init();
        chk(busy == 1, "R10", "busy while requests held", busy, 1);
        wait_done(3, "R10");
        chk(error == 0, "R5", "error cleared by new power-up", error, 1'b0);
        chk(log_n == 8, "R10", "held start before held stop", log_n, 8);
        clear_logs();
        pulse_shut();
        wait_done(1, "R10");
        chk(log_n == 1 && log_dat[0] == 0, "R10", "one user left after held pair", log_n, 1);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_up_tuned();
        t_second_init();
        t_shut_pair();
        t_underflow();
        t_up_plain(1);
        t_up_plain(0);
        t_timeout(2);
        t_timeout(1);
        t_defer();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule